// File: doc/BRIEF.md
# Stray Clock Pulse Filter

This block cleans up the serial clock of a captured SPI-like bus before the clock reaches a byte decoder. A fast system clock samples SCK, MOSI and MISO through a two-flop synchroniser. All three lines then pass through the same fixed-length delay line. While a falling SCK edge waits in the delay line, a history of recent falling edges shows whether another falling edge came within a qualification window on either side of it. Normal data clocks come in bursts with a steady period, so every pulse in a burst has a neighbour and passes through unchanged. A lone low blip has no neighbour. It is removed from the output clock, and the output stays at its idle-high level for the whole length of the blip.

A removed blip still carries timing information, so the block does not drop it silently. For each removed blip it raises a one-cycle flag and keeps a 32-bit timestamp of the cycle in which the blip's falling edge was seen. The timestamp comes from a free-running counter that is cleared by reset. The data lines are never gated, so the decoder sees MOSI and MISO with exactly the same delay as the filtered clock.

The output gate is a two-state machine. FOLLOW copies the delayed SCK to the output. BLANK holds the output high. The transition FOLLOW to BLANK is taken when a reject marker arrives together with the delayed falling edge of an isolated pulse. The transition BLANK to FOLLOW is taken when the delayed SCK is high again.

Top module: `stray_clock_filter`

## Requirements
- R1: While reset is held, sck_out is 1, mosi_out, miso_out and stray_seen are 0, and stray_time is 0.
- R2: mosi_out and miso_out reproduce mosi_in and miso_in exactly, DELAY+2 clock cycles after the rising edge that first samples each input value.
- R3: A SCK pulse whose falling edge has another falling edge no more than WIN cycles before or after it appears on sck_out unchanged, with the same DELAY+2 cycle latency as the data lines.
- R4: A SCK low pulse with no other falling edge within WIN cycles on either side never drives sck_out low. sck_out stays 1 for every cycle the pulse would have occupied.
- R5: For each rejected pulse, stray_seen is 1 for exactly one cycle: the cycle in which the pulse's falling edge would have appeared on sck_out. Otherwise stray_seen is 0.
- R6: When stray_seen is 1, stray_time equals N+1, where N is the number of rising clock edges since reset release, up to and including the edge that first sampled sck_in low for that pulse. stray_time keeps this value until the next rejected pulse.
- R7: The window is inclusive. Two lone pulses whose falling edges are exactly WIN cycles apart both pass. At WIN+1 cycles apart, both are rejected.
- R8: Rejecting a pulse has no effect on mosi_out or miso_out during or around that pulse.
- R9: Several rejected pulses are each reported separately, each with its own stray_time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Asynchronous active-high reset |
| sck_in | input | 1 | Raw serial clock, idle high |
| mosi_in | input | 1 | Raw controller-to-peripheral data |
| miso_in | input | 1 | Raw peripheral-to-controller data |
| sck_out | output | 1 | Delayed serial clock with isolated pulses removed |
| mosi_out | output | 1 | Delayed MOSI, aligned with sck_out |
| miso_out | output | 1 | Delayed MISO, aligned with sck_out |
| stray_seen | output | 1 | One-cycle flag for each rejected pulse |
| stray_time | output | 32 | Counter value of the rejected pulse's falling edge |

## Verification
The assertions assume that every SCK low pulse ends, meaning SCK goes high again, before the next reject marker can arrive. They also assume that DELAY is at least WIN+1, so that the verdict on a pulse is ready before its delayed edge reaches the gate. Without these, BLANK could merge two pulses, or a marker could arrive after the edge it refers to. The stimulus keeps every low phase between three and six cycles long. It surrounds each test group with at least forty idle cycles, which is more than twice the window, so each group's history starts empty. All tests run with the default DELAY of 20 and WIN of 12.

// File: rtl/bcq_pkg.sv
package bcq_pkg;

    // Output gate states
    typedef enum logic {
        GATE_FOLLOW = 1'b0,
        GATE_BLANK  = 1'b1
    } gate_state_t;

    // Bundle of the three bus lines, clock in the top bit
    typedef struct packed {
        logic sck;
        logic mosi;
        logic miso;
    } bus_t;

    localparam int BUS_W = 3;
    localparam logic [BUS_W-1:0] BUS_IDLE = 3'b100;

endpackage

// File: rtl/bcq_sync.sv
module bcq_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bcq_delay.sv
module bcq_delay #(
    parameter int N     = 3,
    parameter int DEPTH = 20,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] line_q [DEPTH];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= RST_VAL;
        end else begin
            line_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
    end

    assign q = line_q[DEPTH-1];
endmodule

// File: rtl/bcq_window.sv
// Falling-edge history with a two-sided neighbour mask. A reject marker
// leaves LAG cycles after the verdict so that it lines up with the
// delayed falling edge of the same pulse.
module bcq_window #(
    parameter int WIN = 12,
    parameter int LAG = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    output logic reject_mark
);
    localparam int HW = 2 * WIN + 1;
    localparam logic [HW-1:0] CENTRE = HW'(1) << WIN;

    logic          sck_prev_q;
    logic          fall_now;
    logic [HW-1:0] hist_q;
    logic          lone;

    assign fall_now = sck_prev_q & ~sck_s;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sck_prev_q <= 1'b1;
            hist_q     <= '0;
        end else begin
            sck_prev_q <= sck_s;
            hist_q     <= {hist_q[HW-2:0], fall_now};
        end
    end

    // Centre edge with no other edge up to WIN cycles on either side
    assign lone = hist_q[WIN] & ~(|(hist_q & ~CENTRE));

    generate
        if (LAG == 0) begin : g_direct
            assign reject_mark = lone;
        end else begin : g_pipe
            logic [LAG-1:0] mark_q;
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    mark_q <= '0;
                end else begin
                    mark_q[0] <= lone;
                    for (int i = 1; i < LAG; i++) mark_q[i] <= mark_q[i-1];
                end
            end
            assign reject_mark = mark_q[LAG-1];
        end
    endgenerate

    // A falling edge needs a high cycle before it, so edges never touch
    assert_edge_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        fall_now |=> !fall_now);
endmodule

// File: rtl/bcq_gate.sv
module bcq_gate
    import bcq_pkg::*;
#(
    parameter int DELAY = 20,
    parameter int TS_W  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_t            dly,
    input  logic            reject_mark,
    input  logic [TS_W-1:0] ts_now,
    output logic            sck_out,
    output logic            mosi_out,
    output logic            miso_out,
    output logic            stray_seen,
    output logic [TS_W-1:0] stray_time
);
    gate_state_t     state_q, state_d;
    logic            sck_d;
    logic            hit;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= GATE_FOLLOW;
        else     state_q <= state_d;
    end

    // Next state and output decode
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        unique case (state_q)
            GATE_FOLLOW: begin
                if (reject_mark) begin
                    state_d = GATE_BLANK;
                    hit     = 1'b1;
                end
            end
            GATE_BLANK: begin
                if (dly.sck) state_d = GATE_FOLLOW;
            end
            default: state_d = GATE_FOLLOW;
        endcase
        sck_d = (state_d == GATE_FOLLOW) ? dly.sck : 1'b1;
    end

    // Registered outputs
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sck_out    <= 1'b1;
            mosi_out   <= 1'b0;
            miso_out   <= 1'b0;
            stray_seen <= 1'b0;
            stray_time <= '0;
        end else begin
            sck_out    <= sck_d;
            mosi_out   <= dly.mosi;
            miso_out   <= dly.miso;
            stray_seen <= hit;
            if (hit) stray_time <= ts_now - TS_W'(DELAY);
        end
    end

    assert_blank_high_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_BLANK) |-> sck_out);

    assert_stray_masked_R4: assert property (@(posedge clk) disable iff (rst)
        stray_seen |-> (sck_out && state_q == GATE_BLANK));

    assert_stray_single_R5: assert property (@(posedge clk) disable iff (rst)
        stray_seen |=> !stray_seen);

    assert_fall_in_follow_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sck_out) |-> (state_q == GATE_FOLLOW));

    assert_time_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (stray_time != $past(stray_time)) |-> stray_seen);
endmodule

// File: rtl/stray_clock_filter.sv
module stray_clock_filter
    import bcq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DELAY       = 20,
    parameter int WIN         = 12,
    parameter int TS_W        = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck_in,
    input  logic            mosi_in,
    input  logic            miso_in,
    output logic            sck_out,
    output logic            mosi_out,
    output logic            miso_out,
    output logic            stray_seen,
    output logic [TS_W-1:0] stray_time
);
    // Marker lag: verdict is WIN+1 cycles after the edge, gate needs DELAY
    localparam int LAG = DELAY - WIN - 1;

    bus_t            raw, synced, delayed;
    logic            reject_mark;
    logic [TS_W-1:0] ts_q;

    assign raw = '{sck: sck_in, mosi: mosi_in, miso: miso_in};

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + 1'b1;
    end

    bcq_sync #(.N(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    bcq_delay #(.N(BUS_W), .DEPTH(DELAY), .RST_VAL(BUS_IDLE)) u_delay (
        .clk (clk),
        .rst (rst),
        .d   (synced),
        .q   (delayed)
    );

    bcq_window #(.WIN(WIN), .LAG(LAG)) u_window (
        .clk         (clk),
        .rst         (rst),
        .sck_s       (synced.sck),
        .reject_mark (reject_mark)
    );

    bcq_gate #(.DELAY(DELAY), .TS_W(TS_W)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .dly         (delayed),
        .reject_mark (reject_mark),
        .ts_now      (ts_q),
        .sck_out     (sck_out),
        .mosi_out    (mosi_out),
        .miso_out    (miso_out),
        .stray_seen  (stray_seen),
        .stray_time  (stray_time)
    );

    // A reject marker always meets the delayed edge of its own pulse
    assert_mark_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
        reject_mark |-> !delayed.sck);
endmodule

// File: tb/sim_stray_clock_filter.sv
module sim_stray_clock_filter;
    localparam int DLY = 20;
    localparam int WIN = 12;
    localparam int LAT = DLY + 3;   // drive at negedge after edge m -> visible at m+LAT

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_in = 1'b1, mosi_in = 1'b0, miso_in = 1'b0;
    logic        sck_out, mosi_out, miso_out, stray_seen;
    logic [31:0] stray_time;

    stray_clock_filter #(.DELAY(DLY), .WIN(WIN)) u0 (
        .clk(clk), .rst(rst), .sck_in(sck_in), .mosi_in(mosi_in), .miso_in(miso_in),
        .sck_out(sck_out), .mosi_out(mosi_out), .miso_out(miso_out),
        .stray_seen(stray_seen), .stray_time(stray_time)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc;
    always @(posedge clk or posedge rst) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int pat   = 0;

    typedef struct {
        int          at;
        int          kind;   // 0 sck, 1 mosi, 2 miso, 3 stray_seen, 4 stray_time
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp_v, cyc);
        end
    endtask

    task automatic push(int at, int kind, logic [31:0] v, string tag);
        exp_t e;
        e.at = at; e.kind = kind; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    // One input cycle plus its expected outputs
    task automatic step(logic s, logic exp_sck, logic exp_stray, string tag);
        logic mo, mi;
        @(negedge clk);
        pat++;
        mo = pat[0] ^ pat[2];
        mi = pat[1];
        sck_in  = s;
        mosi_in = mo;
        miso_in = mi;
        push(cyc + LAT, 0, {31'b0, exp_sck}, {tag, " sck_out"});
        push(cyc + LAT, 1, {31'b0, mo}, "R2/R8 mosi_out");
        push(cyc + LAT, 2, {31'b0, mi}, "R2/R8 miso_out");
        push(cyc + LAT, 3, {31'b0, exp_stray}, "R5 stray_seen");
        if (exp_stray) push(cyc + LAT, 4, cyc + 2, "R6/R9 stray_time");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, "R3 idle");
    endtask

    // One pulse; pass=1 expects it on sck_out, else blanked and reported
    task automatic pulse(int low_w, int high_w, bit pass, string tag);
        for (int i = 0; i < low_w; i++)
            step(1'b0, pass ? 1'b0 : 1'b1, (!pass && i == 0), tag);
        for (int i = 0; i < high_w; i++)
            step(1'b1, 1'b1, 1'b0, tag);
    endtask

    // Monitor: pop and compare items due this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic [31:0] act;
            e = sb.pop_front();
            unique case (e.kind)
                0: act = {31'b0, sck_out};
                1: act = {31'b0, mosi_out};
                2: act = {31'b0, miso_out};
                3: act = {31'b0, stray_seen};
                default: act = stray_time;
            endcase
            if (e.at != cyc) check({e.tag, " schedule"}, cyc, e.at);
            else             check(e.tag, act, e.val);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 sck_out in reset", {31'b0, sck_out}, 32'd1);
        check("R1 mosi_out in reset", {31'b0, mosi_out}, 32'd0);
        check("R1 miso_out in reset", {31'b0, miso_out}, 32'd0);
        check("R1 stray_seen in reset", {31'b0, stray_seen}, 32'd0);
        check("R1 stray_time in reset", stray_time, 32'd0);
        rst = 1'b0;

        idle(10);
        // R3: burst of 8, period 8, falls 8 apart
        for (int i = 0; i < 8; i++) pulse(4, 4, 1'b1, "R3 burst");
        idle(40);
        // R4: lone blip, blanked and reported
        pulse(3, 0, 1'b0, "R4 lone blip");
        idle(40);
        // R7: falls exactly WIN apart, both pass
        pulse(4, WIN - 4, 1'b1, "R7 pair at WIN");
        pulse(4, 0, 1'b1, "R7 pair at WIN");
        idle(40);
        // R7/R9: falls WIN+1 apart, both rejected with their own times
        pulse(4, WIN - 3, 1'b0, "R7 pair at WIN+1");
        pulse(4, 0, 1'b0, "R9 second stray");
        idle(40);
        // R4: short burst then a wide lone pulse far after it
        for (int i = 0; i < 4; i++) pulse(4, 4, 1'b1, "R3 short burst");
        idle(30);
        pulse(6, 0, 1'b0, "R4 lone after burst");
        idle(40);

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        check("R5 queue drained", sb.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule